// File: doc/BRIEF.md
# Multicycle Load/Store Instruction Controller

This block executes a 32-bit, three-operand, load/store instruction set one instruction at a time. There is no pipelining. It holds the program counter, the instruction register, a 32-entry register file and four working registers: two operand latches, an execute result and a writeback value. Each instruction steps through a fixed sequence of states that depends on its class. Every instruction is fetched, then decoded while its source registers are read. It is then executed, or its address is calculated. Only the classes that need them go on to a memory step and a register write step.

The controller shares one memory port between instruction fetch and data access. A read returns the word selected by the address presented in the same cycle. A write takes effect at the clock edge while the write strobe is high. The supported classes are:
- register-register arithmetic
- register-immediate arithmetic
- word load
- word store
- branch on equal
- absolute jump

An opcode or function code outside this set raises a one-cycle illegal flag. The instruction then retires without changing any state except the advanced program counter.

Top module: `mc_core`

## Requirements
- R1: While reset is active, the memory address is 0, the write strobe is 0 and the illegal flag is 0. After reset, the PC starts at 0 and every register reads as 0.
- R2: The fetch cycle drives the PC as the memory address, latches the returned word as the instruction and adds 4 to the PC. The cycle counts per instruction are:
  - register-register, register-immediate and load: 5 cycles
  - store: 4 cycles
  - branch and jump: 3 cycles
  - illegal: 2 cycles
- R3: Register-register form: opcode 0x00 in bits [31:26], first source in [25:21], second source in [20:16], destination in [15:11], bits [10:6] zero, function code in [5:0]. The function codes are add 0x20, subtract 0x22, and 0x24, or 0x25, xor 0x26 and signed set-less-than 0x2A.
- R4: Immediate form: opcode in [31:26], source in [25:21], destination in [20:16], 16-bit immediate in [15:0], sign-extended to 32 bits. The opcodes are add 0x08, signed set-less-than 0x0A, and 0x0C, or 0x0D and xor 0x0E.
- R5: Load (opcode 0x23) reads the word at source plus the sign-extended immediate, with the address forced to a word boundary. The address is presented in the fourth cycle, and the word is written to the register in [20:16].
- R6: Store (opcode 0x2B) writes the register in [20:16] to the word at source plus the sign-extended immediate. The write strobe is high for exactly the fourth cycle, and no register is written.
- R7: Branch (opcode 0x04) compares the registers in [25:21] and [20:16]. When they are equal, the PC becomes the address of the branch plus 4 plus the sign-extended immediate. Otherwise execution continues with the next word.
- R8: Jump (opcode 0x02) loads the PC with bits [31:28] of the incremented PC, then the 26-bit field [25:0], then two zero bits.
- R9: Register 0 reads as zero, and writes to it have no effect.
- R10: An unknown opcode, or a register-register word with an unknown function code or nonzero bits [10:6], raises the illegal flag during its second cycle. The next cycle is a fetch of the following word, and no register is changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Word address for fetch or data access |
| mem_rdata | input | 32 | Read data for the address of the same cycle |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, one cycle |
| illegal_op | output | 1 | High for one cycle on an unrecognised instruction |

## Verification
Each instruction class finishes after a fixed number of cycles, so the bench counts clock edges from reset release and samples on the falling edge that follows the counted edge. A run of ALU instructions places the next fetch address on the bus 5 edges after the previous one. A store raises its strobe on the third edge after its fetch. A branch or jump shows its target 3 edges after its fetch. The illegal flag appears on the edge after the bad word is fetched. Register results are made visible by storing them to memory, and they are read only after the whole program has run.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX   = $clog2(NREG);
  localparam int IMMW   = 16;
  localparam int TGTW   = 26;
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WRITE
  } state_e;

  typedef enum logic [2:0] {
    K_RR, K_RI, K_LD, K_ST, K_BR, K_JMP, K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_e;

  typedef struct packed {
    kind_e            kind;
    alu_e             alu;
    logic [RIDX-1:0]  dst;
  } dec_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] imm);
    return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = '0;
    endcase
    return y;
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq_pc,
                                                input logic [TGTW-1:0] tgt);
    return {seq_pc[XLEN-1:TGTW+2], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  input  logic [4:0]      shamt,
  input  logic [RIDX-1:0] rt_idx,
  input  logic [RIDX-1:0] rd_idx,
  output dec_t            dec
);
  always_comb begin
    dec.kind = K_BAD;
    dec.alu  = ALU_ADD;
    dec.dst  = rt_idx;
    case (opcode)
      OP_RTYPE: begin
        dec.dst  = rd_idx;
        dec.kind = (shamt == '0) ? K_RR : K_BAD;
        case (funct)
          FN_ADD:  dec.alu = ALU_ADD;
          FN_SUB:  dec.alu = ALU_SUB;
          FN_AND:  dec.alu = ALU_AND;
          FN_OR:   dec.alu = ALU_OR;
          FN_XOR:  dec.alu = ALU_XOR;
          FN_SLT:  dec.alu = ALU_SLT;
          default: dec.kind = K_BAD;
        endcase
      end
      OP_ADDI: begin dec.kind = K_RI; dec.alu = ALU_ADD; end
      OP_SLTI: begin dec.kind = K_RI; dec.alu = ALU_SLT; end
      OP_ANDI: begin dec.kind = K_RI; dec.alu = ALU_AND; end
      OP_ORI:  begin dec.kind = K_RI; dec.alu = ALU_OR;  end
      OP_XORI: begin dec.kind = K_RI; dec.alu = ALU_XOR; end
      OP_LW:   dec.kind = K_LD;
      OP_SW:   dec.kind = K_ST;
      OP_BEQ:  dec.kind = K_BR;
      OP_JMP:  dec.kind = K_JMP;
      default: dec.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  alu_e            op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_calc(op, a, b);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic        illegal_op
);
  state_e          state_q, state_d;
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, res_q, wb_q;
  dec_t            dec;

  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx;
  logic [XLEN-1:0] imm_sext, rf_a, rf_b, alu_b, alu_y, seq_addr;

  // named events used by the checker
  logic fetch_evt, rf_we, br_taken, jmp_evt, data_phase;

  assign rs_idx   = ir_q[25:21];
  assign rt_idx   = ir_q[20:16];
  assign rd_idx   = ir_q[15:11];
  assign imm_sext = sext_imm(ir_q[IMMW-1:0]);

  mc_decode u_dec (
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .shamt  (ir_q[10:6]),
    .rt_idx (rt_idx),
    .rd_idx (rd_idx),
    .dec    (dec)
  );

  assign fetch_evt  = (state_q == ST_FETCH);
  assign data_phase = (state_q == ST_MEM);
  assign rf_we      = (state_q == ST_WRITE);
  assign br_taken   = (state_q == ST_EXEC) && (dec.kind == K_BR) && (a_q == b_q);
  assign jmp_evt    = (state_q == ST_EXEC) && (dec.kind == K_JMP);
  assign illegal_op = (state_q == ST_DECODE) && (dec.kind == K_BAD);

  mc_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (dec.dst),
    .wdata   (wb_q),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  assign alu_b = (dec.kind == K_RR) ? b_q : imm_sext;

  mc_alu u_alu (
    .op (dec.alu),
    .a  (a_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign seq_addr  = res_q & ~XLEN'(3);
  assign mem_addr  = data_phase ? seq_addr : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = data_phase && (dec.kind == K_ST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (dec.kind == K_BAD) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   state_d = (dec.kind == K_BR || dec.kind == K_JMP) ? ST_FETCH : ST_MEM;
      ST_MEM:    state_d = (dec.kind == K_ST) ? ST_FETCH : ST_WRITE;
      ST_WRITE:  state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_FETCH: begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + PC_STEP;
        end
        ST_DECODE: begin
          a_q <= rf_a;
          b_q <= rf_b;
        end
        ST_EXEC: begin
          res_q <= alu_y;
          if (br_taken) pc_q <= pc_q + imm_sext;
          if (jmp_evt)  pc_q <= jump_dest(pc_q, ir_q[TGTW-1:0]);
        end
        ST_MEM: begin
          wb_q <= (dec.kind == K_LD) ? mem_rdata : res_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_evt,
  input logic        rf_we,
  input logic        br_taken,
  input logic        jmp_evt,
  input logic        mem_we,
  input logic        illegal_op,
  input logic [31:0] pc_q,
  input logic [31:0] imm_sext
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> pc_q == $past(pc_q) + 32'd4);

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_evt, rf_we, mem_we, illegal_op}));

  assert_write_retires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> fetch_evt);

  assert_store_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && fetch_evt));

  assert_branch_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (fetch_evt && pc_q == $past(pc_q) + $past(imm_sext)));

  assert_jump_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_evt |=> (fetch_evt && pc_q[1:0] == 2'b00));

  assert_illegal_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> (fetch_evt && pc_q == $past(pc_q) && !rf_we));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_evt  (fetch_evt),
  .rf_we      (rf_we),
  .br_taken   (br_taken),
  .jmp_evt    (jmp_evt),
  .mem_we     (mem_we),
  .illegal_op (illegal_op),
  .pc_q       (pc_q),
  .imm_sext   (imm_sext)
);

// File: tb/mc_core_test.sv
module mc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we, illegal_op;
  logic [31:0] mem [128];
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  mc_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .illegal_op (illegal_op)
  );

  assign mem_rdata = mem[mem_addr[8:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;

  // {opcode, funct, operand a, operand b / immediate, expected}
  localparam logic [75:0] VEC [13] = '{
    {6'h00, 6'h20, 16'h0005, 16'h0007, 32'h0000000C},
    {6'h00, 6'h22, 16'h0003, 16'h000A, 32'hFFFFFFF9},
    {6'h00, 6'h24, 16'h0F0F, 16'h00FF, 32'h0000000F},
    {6'h00, 6'h25, 16'h0F00, 16'h00F0, 32'h00000FF0},
    {6'h00, 6'h26, 16'h00FF, 16'h0F0F, 32'h00000FF0},
    {6'h00, 6'h2A, 16'hFFFF, 16'h0001, 32'h00000001},
    {6'h00, 6'h2A, 16'h0002, 16'h0001, 32'h00000000},
    {6'h00, 6'h20, 16'h8000, 16'h8000, 32'hFFFF0000},
    {6'h08, 6'h00, 16'h0064, 16'hFFFF, 32'h00000063},
    {6'h0C, 6'h00, 16'hFFFF, 16'h8001, 32'hFFFF8001},
    {6'h0D, 6'h00, 16'h0010, 16'h0001, 32'h00000011},
    {6'h0A, 6'h00, 16'h8000, 16'h7FFF, 32'h00000001},
    {6'h0E, 6'h00, 16'h1234, 16'h00FF, 32'h000012CB}
  };

  function automatic logic [31:0] enc_rr(logic [4:0] rs, logic [4:0] rt,
                                         logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_ri(logic [5:0] op, logic [4:0] rs,
                                         logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [31:0] dest);
    return {6'h02, dest[27:2]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic hold_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
  endtask

  task automatic release_reset;
    rst_n = 1'b1;
  endtask

  task automatic step(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic branch_prog(logic [15:0] b, logic [31:0] exp, logic [31:0] next_pc);
    hold_reset;
    mem[0] = enc_ri(6'h08, 0, 1, 16'h0007);
    mem[1] = enc_ri(6'h08, 0, 2, b);
    mem[2] = enc_ri(6'h04, 1, 2, 16'h0008);
    mem[3] = enc_ri(6'h08, 0, 3, 16'h0001);
    mem[4] = enc_ri(6'h08, 3, 3, 16'h0002);
    mem[5] = enc_ri(6'h08, 3, 3, 16'h0004);
    mem[6] = enc_ri(6'h2B, 0, 3, 16'h0180);
    mem[7] = enc_j(32'd28);
    release_reset;
    step(13);
    check("R7 fetch address after branch", mem_addr, next_pc);
    step(40);
    check("R7 register after branch program", mem[96], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary;
    $finish;
  end

  initial begin
    // R1: reset state and cleared registers
    hold_reset;
    check("R1 mem_addr in reset", mem_addr, 32'h0);
    check("R1 mem_we in reset", {31'h0, mem_we}, 32'h0);
    check("R1 illegal_op in reset", {31'h0, illegal_op}, 32'h0);
    mem[0]  = enc_ri(6'h2B, 0, 5, 16'h0180);
    mem[1]  = enc_j(32'd4);
    mem[96] = 32'hDEADBEEF;
    release_reset;
    step(20);
    check("R1 register reads zero after reset", mem[96], 32'h0);

    // R3/R4: vector table, with R2/R6 timing on the first program
    for (int v = 0; v < 13; v++) begin
      logic [5:0]  op   = VEC[v][75:70];
      logic [5:0]  fn   = VEC[v][69:64];
      logic [15:0] opa  = VEC[v][63:48];
      logic [15:0] opb  = VEC[v][47:32];
      logic [31:0] exp  = VEC[v][31:0];
      hold_reset;
      mem[0] = enc_ri(6'h08, 0, 1, opa);
      mem[1] = enc_ri(6'h08, 0, 2, opb);
      mem[2] = (op == 6'h00) ? enc_rr(1, 2, 3, fn) : enc_ri(op, 1, 3, opb);
      mem[3] = enc_ri(6'h2B, 0, 3, 16'h0180);
      mem[4] = enc_j(32'd16);
      release_reset;
      if (v == 0) begin
        step(5);
        check("R2 second fetch after 5 cycles", mem_addr, 32'd4);
        step(5);
        check("R2 third fetch after 10 cycles", mem_addr, 32'd8);
        step(5);
        check("R2 store fetch after 15 cycles", mem_addr, 32'd12);
        step(3);
        check("R6 store strobe in 4th cycle", {31'h0, mem_we}, 32'h1);
        check("R6 store address", mem_addr, 32'h180);
        check("R6 store data", mem_wdata, 32'hC);
        step(1);
        check("R6 strobe drops and next fetch", {mem_addr[30:0], mem_we}, {31'd16, 1'b0});
        step(3);
        check("R8 jump to self after 3 cycles", mem_addr, 32'd16);
        step(8);
      end else begin
        step(30);
      end
      check((op == 6'h00) ? "R3 register-register result" : "R4 register-immediate result",
            mem[96], exp);
    end

    // R5: load and store with negative offsets
    hold_reset;
    mem[97] = 32'hCAFE1234;
    mem[0]  = enc_ri(6'h08, 0, 1, 16'h0200);
    mem[1]  = enc_ri(6'h23, 1, 2, 16'hFF84);
    mem[2]  = enc_ri(6'h2B, 1, 2, 16'hFF88);
    mem[3]  = enc_j(32'd12);
    release_reset;
    step(8);
    check("R5 load address in 4th cycle", mem_addr, 32'h184);
    step(30);
    check("R5 loaded word stored back", mem[98], 32'hCAFE1234);

    // R7: branch taken and not taken
    branch_prog(16'h0007, 32'd4, 32'd20);
    branch_prog(16'h0008, 32'd7, 32'd12);

    // R8: jump over two words
    hold_reset;
    mem[0] = enc_j(32'd12);
    mem[1] = enc_ri(6'h08, 0, 3, 16'h0009);
    mem[2] = enc_ri(6'h08, 0, 3, 16'h0009);
    mem[3] = enc_ri(6'h08, 3, 3, 16'h0005);
    mem[4] = enc_ri(6'h2B, 0, 3, 16'h0180);
    mem[5] = enc_j(32'd20);
    release_reset;
    step(3);
    check("R8 jump target fetched", mem_addr, 32'd12);
    step(30);
    check("R8 skipped words not executed", mem[96], 32'd5);

    // R9: register 0 ignores writes
    hold_reset;
    mem[96] = 32'h11111111;
    mem[97] = 32'h22222222;
    mem[0]  = enc_ri(6'h08, 0, 0, 16'h0005);
    mem[1]  = enc_rr(0, 0, 4, 6'h20);
    mem[2]  = enc_ri(6'h2B, 0, 4, 16'h0180);
    mem[3]  = enc_ri(6'h2B, 0, 0, 16'h0184);
    mem[4]  = enc_j(32'd16);
    release_reset;
    step(40);
    check("R9 r0 sum stored", mem[96], 32'h0);
    check("R9 r0 stored directly", mem[97], 32'h0);

    // R10: bad opcode, then bad function code
    hold_reset;
    mem[0] = enc_ri(6'h08, 0, 3, 16'h0055);
    mem[1] = 32'hFC000000;
    mem[2] = enc_rr(1, 2, 3, 6'h3F);
    mem[3] = enc_ri(6'h2B, 0, 3, 16'h0180);
    mem[4] = enc_j(32'd16);
    release_reset;
    step(5);
    check("R10 flag low before bad word", {31'h0, illegal_op}, 32'h0);
    step(1);
    check("R10 flag on bad opcode", {31'h0, illegal_op}, 32'h1);
    step(1);
    check("R10 returns to fetch next word", {mem_addr[30:0], illegal_op}, {31'd8, 1'b0});
    step(1);
    check("R10 flag on bad function code", {31'h0, illegal_op}, 32'h1);
    step(30);
    check("R10 destination unchanged", mem[96], 32'h55);

    summary;
    $finish;
  end
endmodule